// File: doc/BRIEF.md
# Per-Bank SDRAM Write Serializer

This block takes write requests that arrive in any address order and groups them into one queue per SDRAM bank. Each request carries a word address and a data word. A drain arbiter empties the queues into a simplified SDRAM command stream made of activate, write and precharge commands. It keeps one bank in service for as long as the head of that bank's queue falls in the row that is already open. Random writes from a producer, such as a triangle-heap builder, therefore become per-bank bursts inside open rows, and far fewer rows are opened and closed.

Both data sides are valid/ready streams. On the input side a request is taken on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is combinational on `wr_addr`: it drops only when the target bank's queue is full or a flush is in progress, so a producer must keep its request stable while it waits. On the command side a command moves on a rising edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, the command stays fixed. The command consumer is responsible for all SDRAM timing. A flush drains every queue, closes every open row and then pulses `flush_done`, which makes it suitable for a buffer swap at the end of a frame. The write throughput is only balanced when consecutive writes spread across all four banks.

Top module: `sdram_wr_serializer`

## Requirements
- R1: A word address is laid out as {row, bank, column}, with the column in bits [COL_W-1:0] and the bank in bits [COL_W+BANK_W-1:COL_W]. Each accepted write goes into the queue of the bank named by its bank field. The default COL_W of 10 with 32-bit words gives 4 KB rows.
- R2: `wr_ready` is low exactly when the queue of the addressed bank is full or a flush is pending. A full queue never stalls writes to other banks, and `bank_full[b]` reports the full state of bank b's queue.
- R3: Every accepted write leaves exactly once as a write command with its own bank, row, column and data. Writes to the same address leave in the order they were accepted.
- R4: A write command is only issued to a bank whose open row equals the write's row. An activate is only issued to a closed bank, and a precharge only to an open bank. A row miss on an open bank is handled as a precharge, then an activate, then the write.
- R5: Consecutive queued writes that hit the open row of the bank in service are issued with no further activate, so N writes to one row of a closed bank cost exactly one activate.
- R6: The arbiter stays on the current bank while its queue head hits the open row. When the head misses after at least one write in this visit, or when the queue is empty, the arbiter moves to the next non-empty bank in ascending round-robin order. A newly selected bank may open a row.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and every command field hold their values.
- R8: A `flush_req` pulse stalls the input, drains all queues and precharges every open bank. It then raises `flush_done` for exactly one cycle, at which point all queues are empty.
- R9: After reset all queues are empty, no bank is open, `cmd_valid` and `flush_done` are low, and `wr_ready` is high.
- R10: `cmd_op` encodes activate as 2'b01, write as 2'b10 and precharge as 2'b11. A valid command never carries 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request can be taken this cycle |
| wr_addr | input | ADDR_W | Word address {row, bank, column} |
| wr_data | input | DATA_W | Write data word |
| flush_req | input | 1 | One-cycle request to drain and close all banks |
| flush_done | output | 1 | One-cycle pulse when the flush has completed |
| bank_full | output | NUM_BANKS | Per-bank queue full flags |
| bank_empty | output | NUM_BANKS | Per-bank queue empty flags |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command consumer can take a command |
| cmd_op | output | 2 | Command code (see R10) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Row for activate and write |
| cmd_col | output | COL_W | Column for write |
| cmd_data | output | DATA_W | Data for write |

## Verification
The bench builds the block with 2-bit row, bank and column fields, a queue depth of 4 and 16-bit data. This gives a 64-word address space, small enough that whole-space sweeps with several address strides, repeated addresses and irregular `cmd_ready` patterns are cheap. A queue fills within four writes, so the per-bank stall and the other banks' continued acceptance can be observed directly. A bank model driven only by the command stream checks the row protocol. Sequence-numbered data checks exactly-once delivery and same-address ordering. A short fixed scenario compares the exact command order against the round-robin rule.

// File: rtl/sdram_wr_serializer_pkg.sv
package sdram_wr_serializer_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_ACT  = 2'b01,
    OP_WR   = 2'b10,
    OP_PRE  = 2'b11
  } sdram_op_e;
endpackage

// File: rtl/wsr_bank_fifo.sv
module wsr_bank_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [PW:0]      count;

  assign full  = (count == (PW+1)'(DEPTH));
  assign empty = (count == '0);
  assign head  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/wsr_drain_arbiter.sv
module wsr_drain_arbiter
  import sdram_wr_serializer_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 10,
  parameter int DATA_W = 32,
  localparam int NB     = 1 << BANK_W,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NB-1:0]        q_empty,
  input  logic [NB*ADDR_W-1:0] q_head_addr,
  input  logic [NB*DATA_W-1:0] q_head_data,
  output logic [NB-1:0]        q_pop,
  input  logic                 flush_req,
  output logic                 flush_busy,
  output logic                 flush_done,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [1:0]           cmd_op,
  output logic [BANK_W-1:0]    cmd_bank,
  output logic [ROW_W-1:0]     cmd_row,
  output logic [COL_W-1:0]     cmd_col,
  output logic [DATA_W-1:0]    cmd_data
);
  logic [BANK_W-1:0]         cur_q, cur_n;
  logic                      fresh_q, fresh_n;
  logic [NB-1:0]             open_q, open_n;
  logic [NB-1:0][ROW_W-1:0]  orow_q, orow_n;
  logic                      fl_q, fl_n, done_n;
  logic                      v_n;
  sdram_op_e                 op_q, op_n;
  logic [BANK_W-1:0]         bank_n;
  logic [ROW_W-1:0]          row_n;
  logic [COL_W-1:0]          col_n;
  logic [DATA_W-1:0]         data_n;

  logic                      slot_free;
  logic [ADDR_W-1:0]         h_addr;
  logic [ROW_W-1:0]          h_row;
  logic                      nxt_found;
  logic [BANK_W-1:0]         nxt_bank;
  logic                      lo_found;
  logic [BANK_W-1:0]         lo_open;

  assign slot_free = !cmd_valid || cmd_ready;
  assign h_addr    = q_head_addr[cur_q*ADDR_W +: ADDR_W];
  assign h_row     = h_addr[ADDR_W-1 -: ROW_W];

  // next non-empty bank after the current one, wrapping onto itself last
  always_comb begin
    nxt_found = 1'b0;
    nxt_bank  = cur_q;
    for (int i = 1; i <= NB; i++) begin
      if (!nxt_found && !q_empty[cur_q + BANK_W'(i)]) begin
        nxt_found = 1'b1;
        nxt_bank  = cur_q + BANK_W'(i);
      end
    end
  end

  // lowest-numbered open bank, for the closing phase of a flush
  always_comb begin
    lo_found = 1'b0;
    lo_open  = '0;
    for (int b = NB-1; b >= 0; b--) begin
      if (open_q[b]) begin
        lo_found = 1'b1;
        lo_open  = BANK_W'(b);
      end
    end
  end

  always_comb begin
    cur_n   = cur_q;
    fresh_n = fresh_q;
    open_n  = open_q;
    orow_n  = orow_q;
    fl_n    = fl_q | flush_req;
    done_n  = 1'b0;
    v_n     = cmd_valid;
    op_n    = op_q;
    bank_n  = cmd_bank;
    row_n   = cmd_row;
    col_n   = cmd_col;
    data_n  = cmd_data;
    q_pop   = '0;
    if (slot_free) begin
      v_n = 1'b0;
      if (!q_empty[cur_q]) begin
        if (open_q[cur_q] && orow_q[cur_q] == h_row) begin
          v_n          = 1'b1;
          op_n         = OP_WR;
          bank_n       = cur_q;
          row_n        = h_row;
          col_n        = h_addr[COL_W-1:0];
          data_n       = q_head_data[cur_q*DATA_W +: DATA_W];
          q_pop[cur_q] = 1'b1;
          fresh_n      = 1'b0;
        end else if (fresh_q) begin
          v_n    = 1'b1;
          bank_n = cur_q;
          row_n  = h_row;
          if (open_q[cur_q]) begin
            op_n          = OP_PRE;
            open_n[cur_q] = 1'b0;
          end else begin
            op_n          = OP_ACT;
            open_n[cur_q] = 1'b1;
            orow_n[cur_q] = h_row;
          end
        end else begin
          cur_n   = nxt_bank;
          fresh_n = 1'b1;
        end
      end else if (nxt_found) begin
        cur_n   = nxt_bank;
        fresh_n = 1'b1;
      end else if (fl_q) begin
        if (lo_found) begin
          v_n             = 1'b1;
          op_n            = OP_PRE;
          bank_n          = lo_open;
          open_n[lo_open] = 1'b0;
        end else begin
          done_n = 1'b1;
          fl_n   = flush_req;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= '0;
      fresh_q    <= 1'b1;
      open_q     <= '0;
      orow_q     <= '0;
      fl_q       <= 1'b0;
      flush_done <= 1'b0;
      cmd_valid  <= 1'b0;
      op_q       <= OP_NONE;
      cmd_bank   <= '0;
      cmd_row    <= '0;
      cmd_col    <= '0;
      cmd_data   <= '0;
    end else begin
      cur_q      <= cur_n;
      fresh_q    <= fresh_n;
      open_q     <= open_n;
      orow_q     <= orow_n;
      fl_q       <= fl_n;
      flush_done <= done_n;
      cmd_valid  <= v_n;
      op_q       <= op_n;
      cmd_bank   <= bank_n;
      cmd_row    <= row_n;
      cmd_col    <= col_n;
      cmd_data   <= data_n;
    end
  end

  assign cmd_op     = op_q;
  assign flush_busy = fl_q;

  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_bank)
      && $stable(cmd_row) && $stable(cmd_col) && $stable(cmd_data));
  assert_wr_open_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_WR |-> open_q[cmd_bank] && orow_q[cmd_bank] == cmd_row);
  assert_op_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_op != OP_NONE);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);
  assert_done_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> open_q == '0 && &q_empty);
endmodule

// File: rtl/sdram_wr_serializer.sv
module sdram_wr_serializer #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 10,
  parameter int DATA_W = 32,
  parameter int QDEPTH = 16,
  localparam int NUM_BANKS = 1 << BANK_W,
  localparam int ADDR_W    = ROW_W + BANK_W + COL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 flush_req,
  output logic                 flush_done,
  output logic [NUM_BANKS-1:0] bank_full,
  output logic [NUM_BANKS-1:0] bank_empty,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [1:0]           cmd_op,
  output logic [BANK_W-1:0]    cmd_bank,
  output logic [ROW_W-1:0]     cmd_row,
  output logic [COL_W-1:0]     cmd_col,
  output logic [DATA_W-1:0]    cmd_data
);
  localparam int EW = ADDR_W + DATA_W;

  logic [BANK_W-1:0]           in_bank;
  logic                        take;
  logic                        busy;
  logic [NUM_BANKS-1:0]        pop;
  logic [NUM_BANKS*ADDR_W-1:0] head_addr;
  logic [NUM_BANKS*DATA_W-1:0] head_data;

  assign in_bank  = wr_addr[COL_W +: BANK_W];
  assign wr_ready = !busy && !bank_full[in_bank];
  assign take     = wr_valid && wr_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [EW-1:0] head;
    wsr_bank_fifo #(.WIDTH(EW), .DEPTH(QDEPTH)) fifo_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (take && in_bank == BANK_W'(b)),
      .push_data({wr_addr, wr_data}),
      .pop      (pop[b]),
      .head     (head),
      .full     (bank_full[b]),
      .empty    (bank_empty[b])
    );
    assign head_addr[b*ADDR_W +: ADDR_W] = head[EW-1 -: ADDR_W];
    assign head_data[b*DATA_W +: DATA_W] = head[DATA_W-1:0];
  end

  wsr_drain_arbiter #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) arb_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_empty    (bank_empty),
    .q_head_addr(head_addr),
    .q_head_data(head_data),
    .q_pop      (pop),
    .flush_req  (flush_req),
    .flush_busy (busy),
    .flush_done (flush_done),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_bank   (cmd_bank),
    .cmd_row    (cmd_row),
    .cmd_col    (cmd_col),
    .cmd_data   (cmd_data)
  );

  assert_steer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !bank_empty[$past(in_bank)]);
  assert_stall_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && bank_full[in_bank] |-> !wr_ready);
endmodule

// File: tb/sdram_wr_serializer_tb_top.sv
module sdram_wr_serializer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 2, RW = 2, CW = 2, DW = 16, QD = 4;
  localparam int AW = RW + BW + CW;
  localparam int NB = 1 << BW;
  localparam int MAXSEQ = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, flush_req = 1'b0, cmd_ready = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, flush_done, cmd_valid;
  logic [NB-1:0] bank_full, bank_empty;
  logic [1:0] cmd_op;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;
  logic [DW-1:0] cmd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_wr_serializer #(.BANK_W(BW), .ROW_W(RW), .COL_W(CW), .DATA_W(DW), .QDEPTH(QD)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .flush_req(flush_req),
    .flush_done(flush_done), .bank_full(bank_full), .bank_empty(bank_empty),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_data(cmd_data));

  int compared = 0, mismatched = 0, nseq = 0, cyc = 0, act_cnt = 0;
  int ready_mode = 1;  // 0: always ready, 1: stalled, 2: irregular
  logic [AW-1:0] addr_of [MAXSEQ];
  bit seen [MAXSEQ];
  int last_d [1 << AW];
  bit mopen [NB];
  int mrow [NB];
  bit log_en = 0;
  int log_n = 0;
  int log_op [32];
  int log_bk [32];
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // command monitor and bank model
  always @(negedge clk) begin
    cyc++;
    cmd_ready = (ready_mode == 0) || (ready_mode == 2 && (cyc % 3 != 0) && (cyc % 7 != 2));
    #1;
    if (rst_n && cmd_valid && cmd_ready) begin
      if (log_en && log_n < 32) begin
        log_op[log_n] = int'(cmd_op); log_bk[log_n] = int'(cmd_bank); log_n++;
      end
      case (cmd_op)
        2'b01: begin
          chk(!mopen[cmd_bank], "R4 activate on closed bank", int'(mopen[cmd_bank]), 0);
          mopen[cmd_bank] = 1; mrow[cmd_bank] = int'(cmd_row); act_cnt++;
        end
        2'b11: begin
          chk(mopen[cmd_bank], "R4 precharge on open bank", int'(mopen[cmd_bank]), 1);
          mopen[cmd_bank] = 0;
        end
        2'b10: begin
          int s;
          logic [AW-1:0] a;
          s = int'(cmd_data);
          a = {cmd_row, cmd_bank, cmd_col};
          chk(mopen[cmd_bank] && mrow[cmd_bank] == int'(cmd_row), "R4 write hits open row",
              int'(cmd_row), mrow[cmd_bank]);
          if (s < nseq) begin
            chk(!seen[s], "R3 write delivered once", int'(seen[s]), 0);
            chk(addr_of[s] == a, "R1 write keeps bank/row/col", int'(a), int'(addr_of[s]));
            chk(s > last_d[a], "R3 same-address order", s, last_d[a] + 1);
            seen[s] = 1; last_d[a] = s;
          end else chk(0, "R3 write of unknown data", s, nseq - 1);
        end
        default: chk(0, "R10 valid command code", int'(cmd_op), 1);
      endcase
    end
  end

  task automatic push(input int addr);
    @(negedge clk);
    wr_valid = 1; wr_addr = AW'(addr); wr_data = DW'(nseq);
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    addr_of[nseq] = AW'(addr); nseq++;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush_req = 1;
    @(negedge clk); flush_req = 0;
    #2;
    wr_addr = '0;
    #1;
    chk(!wr_ready || flush_done, "R8 input stalled during flush", int'(wr_ready), 0);
    while (!flush_done) @(negedge clk);
    #2;
    chk(bank_empty == '1, "R8 queues empty at done", int'(bank_empty), NB - 1);
    for (int b = 0; b < NB; b++) chk(!mopen[b], "R8 bank closed at done", int'(mopen[b]), 0);
    for (int s = 0; s < nseq; s++) if (!seen[s]) chk(0, "R3 write missing", s, 1);
    compared++;
    @(negedge clk); #2;
    chk(!flush_done, "R8 done is one cycle", int'(flush_done), 0);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) last_d[i] = -1;
    for (int b = 0; b < NB; b++) begin mopen[b] = 0; mrow[b] = 0; end
    ready_mode = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    // R9 reset state
    chk(bank_empty == '1, "R9 queues empty", int'(bank_empty), NB - 1);
    chk(bank_full == '0, "R9 no queue full", int'(bank_full), 0);
    chk(!cmd_valid, "R9 no command", int'(cmd_valid), 0);
    chk(!flush_done, "R9 no done", int'(flush_done), 0);
    chk(wr_ready, "R9 input ready", int'(wr_ready), 1);

    // R6 arbitration order: b0 row0, b0 row1, b1 row0 loaded while stalled
    push(0); push(16); push(4);
    log_en = 1; ready_mode = 0;
    wait_cycles(30);
    log_en = 0;
    begin
      int eo [7];
      int eb [7];
      eo = '{1, 2, 1, 2, 3, 1, 2};
      eb = '{0, 0, 1, 1, 0, 0, 0};
      chk(log_n == 7, "R6 command count", log_n, 7);
      for (int i = 0; i < 7; i++)
        chk(log_op[i] == eo[i] && log_bk[i] == eb[i], "R6 round-robin order",
            log_op[i] * 10 + log_bk[i], eo[i] * 10 + eb[i]);
    end
    do_flush();

    // R5 grouping: three writes to bank 2 row 3
    ready_mode = 1; act_cnt = 0;
    push(6'b11_10_00); push(6'b11_10_01); push(6'b11_10_11);
    ready_mode = 0;
    wait_cycles(20);
    chk(act_cnt == 1, "R5 one activate per open-row group", act_cnt, 1);
    do_flush();

    // R2 per-bank backpressure: fill bank 3
    ready_mode = 1;
    for (int i = 0; i < QD; i++) push(12 + i);
    @(negedge clk);
    wr_addr = 6'd12; #1;
    chk(bank_full == 4'b1000, "R2 bank 3 full flag", int'(bank_full), 8);
    chk(!wr_ready, "R2 stall on full bank", int'(wr_ready), 0);
    wr_addr = 6'd4; #1;
    chk(wr_ready, "R2 other bank still accepted", int'(wr_ready), 1);
    push(5);
    chk(!bank_empty[1], "R1 bank 1 holds its write", int'(bank_empty[1]), 0);
    ready_mode = 0;
    do_flush();

    // sweeps over the whole address space
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 2; m++) begin
        ready_mode = (m == 0) ? 2 : 0;
        for (int i = 0; i < 64; i++) begin
          int a;
          case (p)
            0: a = i;
            1: a = (i * 5 + 3) % 64;
            2: a = (i * 27) % 64;
            default: a = (i % 3) * 21;
          endcase
          push(a);
        end
        do_flush();
      end
    end

    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule